// File: doc/BRIEF.md
# Configurable 8-bit Image Filter Array

This block is a programmable grayscale filter for a 3×3 pixel window. Each accepted beat carries nine 8-bit pixels: the centre pixel and its eight neighbours. It also carries a reference pixel. The pixels pass through a grid of NC columns by NR rows of two-operand processing nodes. The default grid is 8 columns by 4 rows. Each node picks two operands, applies one of a small set of cheap 8-bit operations, and registers the result. Nodes in the first column pick their operands from the nine window lanes. Every later node picks its operands only from the nodes of the column directly before it. One node of the last column is chosen as the filtered output pixel.

A write port loads each node's operand selects and operation code, and it also selects the output row. This is how a search engine or a fixed setup places a candidate filter into the grid. Every filtered pixel that leaves the block is compared with the reference pixel that entered with the same beat. The block adds the absolute difference to a frame total. After a programmed number of pixels, which defaults to 128×128, it raises a done flag. The total divided by the pixel count is the mean error per pixel that is used to rank candidate filters.

Top module: `cgpf_filter`

## Requirements
- R1: After synchronous reset, `out_valid`, `sad_total` and `sad_done` are 0 and `in_ready` is 1. All genes are zero and the output row is 0, so the array passes lane 0 (the centre pixel) through unchanged.
- R2: Window lane k is `in_pix[8k+7:8k]`, and lane 0 is the centre pixel. A first-column select value below 9 reads that lane. A select of 9 to 15 reads lane 0. A select in a later column reads row s of the previous column when s < NR, and row 0 when s ≥ NR.
- R3: Operation codes, where x is operand A and y is operand B: 0 passes x, 1 gives x>>1, 2 gives x>>2, 3 swaps the nibbles of x, 4 gives x|y, 5 gives x&y, 6 gives x^y, 7 gives (x+y) mod 256, 8 gives the saturating sum, 9 gives the average, 10 gives max, 11 gives min. Codes 12 to 15 pass x.
- R4: The saturating sum is min(x+y, 255). The average is floor((x+y)/2), computed from the full 9-bit sum, so 255 averaged with 255 gives 255. Code 7 wraps modulo 256.
- R5: When there is no backpressure, a beat accepted at a clock edge appears on `out_pix` with `out_valid` high after NC edges, counting the accepting edge. Beats leave in the order they were accepted.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid` and `out_pix` hold. No beat is lost or duplicated.
- R7: A write with `cfg_addr` = col·NR + row below NC·NR loads that node's gene. The gene layout is operand A select in bits [11:8], operand B select in [7:4] and operation code in [3:0]. Writes to addresses above NC·NR are ignored.
- R8: A write to address NC·NR sets the output row from gene bits [1:0]. `out_pix` is the registered result of that row in the last column.
- R9: Each output handshake adds |out_pix − ref| to `sad_total`. Here ref is the `in_ref` value accepted with the same beat.
- R10: A `frame_start` pulse clears the total, the pixel count and `sad_done`. An output handshake in the same cycle counts as the first pixel of the new frame.
- R11: One cycle after the FRAME_PIX-th handshake of a frame, `sad_done` is 1. From then until the next `frame_start`, the total is frozen and further outputs are not added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Node index col·NR+row, or NC·NR for the output row |
| cfg_gene | input | 12 | Select A, select B, operation code |
| in_valid | input | 1 | Window beat valid |
| in_ready | output | 1 | Window beat accepted when high |
| in_pix | input | 72 | Nine 8-bit window lanes, lane 0 is the centre |
| in_ref | input | 8 | Reference pixel for this window |
| out_valid | output | 1 | Filtered pixel valid |
| out_ready | input | 1 | Downstream accepts the filtered pixel |
| out_pix | output | 8 | Filtered pixel |
| frame_start | input | 1 | Clears the error accumulator |
| sad_total | output | 22 | Sum of absolute differences of the frame |
| sad_done | output | 1 | Frame pixel count reached |

## Verification
A filtered pixel is due NC clock edges after the edge that accepts its window. The bench records the accepting edge when its driver commits a beat. The monitor samples on falling edges, so it sees the first valid output exactly NC−1 edge counts later, and it checks that distance whenever backpressure is off. The error total and the done flag change one edge after the output handshake. At every falling edge the monitor therefore first compares them with the reference model as it stood after the previous edge, and only then applies the handshake about to happen. Under random backpressure, each stalled cycle is followed by a check that the held pixel did not move.

// File: rtl/cgpf_pkg.sv
package cgpf_pkg;

    localparam int PIX_W   = 8;
    localparam int FN_W    = 4;
    localparam int SEL_W   = 4;
    localparam int GENE_W  = 2 * SEL_W + FN_W;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [FN_W-1:0] {
        FN_PASS = 4'd0,
        FN_SHR1 = 4'd1,
        FN_SHR2 = 4'd2,
        FN_SWAP = 4'd3,
        FN_OR   = 4'd4,
        FN_AND  = 4'd5,
        FN_XOR  = 4'd6,
        FN_ADD  = 4'd7,
        FN_ADDS = 4'd8,
        FN_AVG  = 4'd9,
        FN_MAX  = 4'd10,
        FN_MIN  = 4'd11
    } fn_e;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [FN_W-1:0]  fn;
    } gene_t;

    function automatic pix_t swap_halves(pix_t x);
        return {x[PIX_W/2-1:0], x[PIX_W-1:PIX_W/2]};
    endfunction

    function automatic pix_t node_eval(logic [FN_W-1:0] code, pix_t x, pix_t y);
        logic [PIX_W:0] wide;
        pix_t           res;
        wide = {1'b0, x} + {1'b0, y};
        case (code)
            FN_SHR1: res = x >> 1;
            FN_SHR2: res = x >> 2;
            FN_SWAP: res = swap_halves(x);
            FN_OR:   res = x | y;
            FN_AND:  res = x & y;
            FN_XOR:  res = x ^ y;
            FN_ADD:  res = wide[PIX_W-1:0];
            FN_ADDS: res = wide[PIX_W] ? pix_t'(PIX_MAX) : wide[PIX_W-1:0];
            FN_AVG:  res = wide[PIX_W:1];
            FN_MAX:  res = (x > y) ? x : y;
            FN_MIN:  res = (x < y) ? x : y;
            default: res = x;
        endcase
        return res;
    endfunction

    function automatic pix_t abs_diff(pix_t a, pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/cgpf_node.sv
module cgpf_node
    import cgpf_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  gene_t gene,
    input  pix_t  srcs [N_SRC],
    output pix_t  q
);

    pix_t op_a;
    pix_t op_b;

    // Operand pick: a select outside the source range falls back to source 0 (R2)
    always_comb begin
        op_a = srcs[0];
        op_b = srcs[0];
        for (int i = 0; i < N_SRC; i++) begin
            if (gene.src_a == SEL_W'(i)) op_a = srcs[i];
            if (gene.src_b == SEL_W'(i)) op_b = srcs[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (adv) q <= node_eval(gene.fn, op_a, op_b);
    end

    // R4: saturating sum never falls below either operand
    a_r4_sat_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && gene.fn == FN_ADDS) |=> (q >= $past(op_a) && q >= $past(op_b)));

    // R4: average lies between the operands
    a_r4_avg_bounded: assert property (@(posedge clk) disable iff (rst)
        (adv && gene.fn == FN_AVG) |=>
            ((q >= $past(op_a) || q >= $past(op_b)) &&
             (q <= $past(op_a) || q <= $past(op_b))));

    // R3: maximum is not below either operand
    a_r3_max_not_below: assert property (@(posedge clk) disable iff (rst)
        (adv && gene.fn == FN_MAX) |=> (q >= $past(op_a) && q >= $past(op_b)));

endmodule

// File: rtl/cgpf_column.sv
module cgpf_column
    import cgpf_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int NR    = 4,
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             cfg_we,
    input  logic [ROW_W-1:0] cfg_row,
    input  gene_t            cfg_gene,
    input  pix_t             srcs [N_SRC],
    output pix_t             q    [NR]
);

    for (genvar r = 0; r < NR; r++) begin : g_row
        gene_t gene_q;
        pix_t  node_q;

        always_ff @(posedge clk) begin
            if (rst)
                gene_q <= '0;
            else if (cfg_we && cfg_row == ROW_W'(r))
                gene_q <= cfg_gene;
        end

        cgpf_node #(.N_SRC(N_SRC)) u_node (
            .clk  (clk),
            .rst  (rst),
            .adv  (adv),
            .gene (gene_q),
            .srcs (srcs),
            .q    (node_q)
        );

        assign q[r] = node_q;
    end

endmodule

// File: rtl/cgpf_sad.sv
module cgpf_sad
    import cgpf_pkg::*;
#(
    parameter int FRAME_PIX = 16384,
    parameter int SAD_W     = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             fire,
    input  pix_t             pix,
    input  pix_t             ref_pix,
    output logic [SAD_W-1:0] total,
    output logic             done
);

    localparam int CNT_W = $clog2(FRAME_PIX + 1);

    logic [SAD_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    pix_t             diff;
    logic             last;

    assign diff = abs_diff(pix, ref_pix);
    assign last = (cnt_q == CNT_W'(FRAME_PIX - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (frame_start) begin
            acc_q  <= fire ? SAD_W'(diff) : '0;
            cnt_q  <= fire ? CNT_W'(1) : '0;
            done_q <= fire && (FRAME_PIX == 1);
        end else if (fire && !done_q) begin
            acc_q <= acc_q + SAD_W'(diff);
            cnt_q <= cnt_q + 1'b1;
            if (last) done_q <= 1'b1;
        end
    end

    assign total = acc_q;
    assign done  = done_q;

    // R11: once complete, the frame total is frozen until a new frame
    a_r11_done_freezes: assert property (@(posedge clk) disable iff (rst)
        (done_q && !frame_start) |=> (done_q && $stable(acc_q)));

    // R11: completion only when the full count is reached
    a_r11_done_at_full_count: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (cnt_q == CNT_W'(FRAME_PIX)));

    // R10: a frame start with no handshake leaves an empty total
    a_r10_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !fire) |=> (acc_q == '0 && !done_q));

    // R9: accumulation never shrinks the total
    a_r9_total_grows: assert property (@(posedge clk) disable iff (rst)
        (fire && !frame_start && !done_q) |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/cgpf_filter.sv
module cgpf_filter
    import cgpf_pkg::*;
#(
    parameter int  NC        = 8,
    parameter int  NR        = 4,
    parameter int  NI        = 9,
    parameter int  FRAME_PIX = 16384,
    localparam int ADDR_W    = $clog2(NC * NR + 1),
    localparam int SAD_W     = $clog2(FRAME_PIX * PIX_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [GENE_W-1:0]   cfg_gene,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [NI*PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0]    in_ref,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [PIX_W-1:0]    out_pix,
    input  logic                frame_start,
    output logic [SAD_W-1:0]    sad_total,
    output logic                sad_done
);

    localparam int N_NODES = NC * NR;
    localparam int ROW_W   = (NR > 1) ? $clog2(NR) : 1;

    logic             adv;
    logic             out_fire;
    logic [NC-1:0]    vld_q;
    pix_t             ref_q   [NC];
    pix_t             win     [NI];
    pix_t             stage_q [NC][NR];
    logic [NC-1:0]    col_we;
    logic [ROW_W-1:0] cfg_row;
    logic [ROW_W-1:0] out_row_q;

    // Whole array advances together; a held output stalls every column
    assign adv      = !vld_q[NC-1] || out_ready;
    assign in_ready = adv;
    assign out_fire = out_valid && out_ready;

    // Configuration address decode: node index = col*NR + row
    always_comb begin
        cfg_row = ROW_W'(int'(cfg_addr) % NR);
        for (int c = 0; c < NC; c++)
            col_we[c] = cfg_we && (int'(cfg_addr) < N_NODES) &&
                        ((int'(cfg_addr) / NR) == c);
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_row_q <= '0;
        else if (cfg_we && int'(cfg_addr) == N_NODES)
            out_row_q <= cfg_gene[ROW_W-1:0];
    end

    for (genvar k = 0; k < NI; k++) begin : g_lane
        assign win[k] = in_pix[k*PIX_W +: PIX_W];
    end

    for (genvar c = 0; c < NC; c++) begin : g_col
        if (c == 0) begin : g_first
            cgpf_column #(.N_SRC(NI), .NR(NR), .ROW_W(ROW_W)) u_col (
                .clk      (clk),
                .rst      (rst),
                .adv      (adv),
                .cfg_we   (col_we[c]),
                .cfg_row  (cfg_row),
                .cfg_gene (gene_t'(cfg_gene)),
                .srcs     (win),
                .q        (stage_q[c])
            );
        end else begin : g_next
            cgpf_column #(.N_SRC(NR), .NR(NR), .ROW_W(ROW_W)) u_col (
                .clk      (clk),
                .rst      (rst),
                .adv      (adv),
                .cfg_we   (col_we[c]),
                .cfg_row  (cfg_row),
                .cfg_gene (gene_t'(cfg_gene)),
                .srcs     (stage_q[c-1]),
                .q        (stage_q[c])
            );
        end
    end

    // Valid flags and reference pixels travel beside the node columns
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int c = 0; c < NC; c++) ref_q[c] <= '0;
        end else if (adv) begin
            vld_q[0] <= in_valid;
            ref_q[0] <= in_ref;
            for (int c = 1; c < NC; c++) begin
                vld_q[c] <= vld_q[c-1];
                ref_q[c] <= ref_q[c-1];
            end
        end
    end

    always_comb begin
        out_pix = stage_q[NC-1][0];
        for (int r = 0; r < NR; r++)
            if (out_row_q == ROW_W'(r)) out_pix = stage_q[NC-1][r];
    end

    assign out_valid = vld_q[NC-1];

    cgpf_sad #(.FRAME_PIX(FRAME_PIX), .SAD_W(SAD_W)) u_sad (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .fire        (out_fire),
        .pix         (out_pix),
        .ref_pix     (ref_q[NC-1]),
        .total       (sad_total),
        .done        (sad_done)
    );

    // R6: a refused output stays presented
    a_r6_stall_keeps_valid: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    // R6: a refused output pixel does not change
    a_r6_stall_keeps_pix: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !cfg_we) |=> $stable(out_pix));

endmodule

// File: tb/tb_cgpf_filter.sv
module tb_cgpf_filter;

    localparam int NC     = 8;
    localparam int NR     = 4;
    localparam int NI     = 9;
    localparam int FP     = 24;
    localparam int ADDR_W = $clog2(NC * NR + 1);
    localparam int SAD_W  = $clog2(FP * 255 + 1);
    localparam int ROWREG = NC * NR;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [11:0]       cfg_gene = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [NI*8-1:0]   in_pix = '0;
    logic [7:0]        in_ref = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [7:0]        out_pix;
    logic              frame_start = 1'b0;
    logic [SAD_W-1:0]  sad_total;
    logic              sad_done;

    cgpf_filter #(.NC(NC), .NR(NR), .NI(NI), .FRAME_PIX(FP)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_gene(cfg_gene), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_ref(in_ref), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix), .frame_start(frame_start),
        .sad_total(sad_total), .sad_done(sad_done)
    );

    int total_chk = 0;
    int bad_chk   = 0;
    int cyc       = 0;
    always @(posedge clk) cyc++;

    task automatic check(bit ok, string req, string what, int act, int exp);
        total_chk++;
        if (!ok) begin
            bad_chk++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model of the configuration
    int m_a [NC][NR];
    int m_b [NC][NR];
    int m_f [NC][NR];
    int m_row = 0;

    function automatic int fn_model(int f, int a, int b);
        case (f)
            0:  return a;
            1:  return a / 2;
            2:  return a / 4;
            3:  return ((a & 15) << 4) | (a >> 4);
            4:  return a | b;
            5:  return a & b;
            6:  return a ^ b;
            7:  return (a + b) % 256;
            8:  return (a + b > 255) ? 255 : a + b;
            9:  return (a + b) / 2;
            10: return (a > b) ? a : b;
            11: return (a < b) ? a : b;
            default: return a;
        endcase
    endfunction

    function automatic int model_out(int w[NI]);
        int prev [NI];
        int cur  [NI];
        int cnt, a, b;
        prev = w;
        cur  = w;
        for (int c = 0; c < NC; c++) begin
            cnt = (c == 0) ? NI : NR;
            for (int r = 0; r < NR; r++) begin
                a = (m_a[c][r] < cnt) ? prev[m_a[c][r]] : prev[0];
                b = (m_b[c][r] < cnt) ? prev[m_b[c][r]] : prev[0];
                cur[r] = fn_model(m_f[c][r], a, b);
            end
            prev = cur;
        end
        return prev[m_row];
    endfunction

    typedef struct {
        int    pix;
        int    rf;
        int    edge_no;
        bit    lat;
        string req;
    } item_t;
    item_t sb[$];

    bit    lat_mode = 1'b1;
    bit    bp_mode  = 1'b0;
    string cur_req  = "R1";

    task automatic cfg_wr(int addr, int sa, int sb_sel, int f);
        @(negedge clk); #3;
        cfg_we   = 1'b1;
        cfg_addr = ADDR_W'(addr);
        cfg_gene = {4'(sa), 4'(sb_sel), 4'(f)};
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (addr < NC * NR) begin
            m_a[addr / NR][addr % NR] = sa;
            m_b[addr / NR][addr % NR] = sb_sel;
            m_f[addr / NR][addr % NR] = f;
        end else if (addr == ROWREG) begin
            m_row = f & (NR - 1);
        end
    endtask

    task automatic send(int w[NI], int rf);
        item_t it;
        @(negedge clk); #2;
        in_valid = 1'b1;
        for (int k = 0; k < NI; k++) in_pix[k*8 +: 8] = 8'(w[k]);
        in_ref = 8'(rf);
        while (!in_ready) begin
            @(negedge clk); #2;
        end
        it.pix     = model_out(w);
        it.rf      = rf;
        it.edge_no = cyc + 1;
        it.lat     = lat_mode && !bp_mode;
        it.req     = cur_req;
        sb.push_back(it);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic send_rand(int n);
        int w [NI];
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < NI; k++) w[k] = $urandom_range(0, 255);
            send(w, $urandom_range(0, 255));
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor / scoreboard with the error-total model
    int  exp_acc  = 0;
    int  exp_cnt  = 0;
    bit  exp_done = 1'b0;
    bit  fs_req   = 1'b0;
    bit  fs_prev  = 1'b0;
    bit  hold_pending = 1'b0;
    int  hold_pix = 0;

    always @(negedge clk) begin
        item_t it;
        bit    fire;
        int    d;
        if (!rst) begin
            // State shown now is the result of the previous edge
            check(sad_total == SAD_W'(exp_acc), fs_prev ? "R10" : (exp_done ? "R11" : "R9"),
                  "sad_total", int'(sad_total), exp_acc);
            check(sad_done == exp_done, fs_prev ? "R10" : "R11", "sad_done",
                  int'(sad_done), int'(exp_done));
            if (hold_pending) begin
                check(out_valid == 1'b1, "R6", "held out_valid", int'(out_valid), 1);
                check(int'(out_pix) == hold_pix, "R6", "held out_pix", int'(out_pix), hold_pix);
            end
            out_ready    = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
            fire         = out_valid && out_ready;
            hold_pending = out_valid && !out_ready;
            hold_pix     = int'(out_pix);
            d = 0;
            if (fire) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5", "unexpected output", int'(out_pix), -1);
                end else begin
                    it = sb.pop_front();
                    check(int'(out_pix) == it.pix, it.req, "out_pix", int'(out_pix), it.pix);
                    if (it.lat)
                        check(cyc - it.edge_no == NC - 1, "R5", "latency edges",
                              cyc - it.edge_no + 1, NC);
                    d = (it.pix > it.rf) ? it.pix - it.rf : it.rf - it.pix;
                end
            end
            fs_prev = fs_req;
            if (fs_req) begin
                // R10: clear, a same-cycle handshake opens the new frame
                frame_start = 1'b1;
                exp_acc  = fire ? d : 0;
                exp_cnt  = fire ? 1 : 0;
                exp_done = fire && (FP == 1);
                fs_req   = 1'b0;
            end else begin
                frame_start = 1'b0;
                if (fire && !exp_done) begin
                    exp_acc += d;
                    exp_cnt++;
                    if (exp_cnt == FP) exp_done = 1'b1;
                end
            end
        end
    end

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad_chk++;
        total_chk++;
        $display("FAIL R5 watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    initial begin
        int w [NI];
        int saved;
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NR; r++) begin
                m_a[c][r] = 0; m_b[c][r] = 0; m_f[c][r] = 0;
            end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #3;
        check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
        check(sad_total == '0, "R1", "reset sad_total", int'(sad_total), 0);
        check(sad_done == 1'b0, "R1", "reset sad_done", int'(sad_done), 0);

        // R1: default genes pass the centre pixel
        cur_req = "R1";
        send_rand(6);
        drain();

        // R3 / R4: every operation code on column 0 row 0
        for (int f = 0; f < 16; f++) begin
            cfg_wr(0, 1, 2, f);
            cur_req = (f >= 7 && f <= 9) ? "R4" : "R3";
            for (int p = 0; p < 6; p++) begin
                for (int k = 0; k < NI; k++) w[k] = $urandom_range(0, 255);
                case (p)
                    0: begin w[1] = 200; w[2] = 100; end
                    1: begin w[1] = 255; w[2] = 255; end
                    2: begin w[1] = 0;   w[2] = 0;   end
                    3: begin w[1] = 60;  w[2] = 165; end
                    4: begin w[1] = 17;  w[2] = 240; end
                    default: ;
                endcase
                send(w, $urandom_range(0, 255));
            end
            drain();
        end
        cfg_wr(0, 0, 0, 0);

        // R2: lane addressing and out-of-range selects
        cur_req = "R2";
        cfg_wr(1, 8, 12, 6);
        cfg_wr(NR + 0, 1, 0, 0);
        cfg_wr(3 * NR + 0, 9, 0, 0);
        send_rand(8);
        cfg_wr(0, 15, 3, 4);
        cfg_wr(NR + 0, 0, 0, 0);
        send_rand(6);
        drain();

        // R8: output row selects a last-column node
        cur_req = "R8";
        cfg_wr(ROWREG, 0, 0, 2);
        cfg_wr((NC - 1) * NR + 2, 0, 1, 10);
        cfg_wr((NC - 2) * NR + 1, 0, 0, 3);
        send_rand(8);
        drain();

        // R7: writes above the row register are ignored
        cur_req = "R7";
        cfg_wr(ROWREG + 5, 15, 15, 15);
        cfg_wr(ROWREG + 12, 1, 1, 1);
        send_rand(6);
        drain();

        // R5: random full configuration, no backpressure
        for (int a = 0; a < NC * NR; a++)
            cfg_wr(a, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15));
        cfg_wr(ROWREG, 0, 0, $urandom_range(0, 3));
        cur_req = "R5";
        send_rand(20);
        drain();

        // R6: random backpressure
        cur_req = "R6";
        lat_mode = 1'b0;
        bp_mode  = 1'b1;
        send_rand(40);
        drain();
        bp_mode  = 1'b0;
        repeat (2) @(negedge clk);
        lat_mode = 1'b1;

        // R9 / R11: one full frame, then ignored extras
        cur_req = "R9";
        fs_req = 1'b1;
        repeat (3) @(negedge clk);
        send_rand(FP);
        drain();
        #3;
        check(sad_done == 1'b1, "R11", "done after frame", int'(sad_done), 1);
        saved = int'(sad_total);
        send_rand(3);
        drain();
        #3;
        check(int'(sad_total) == saved, "R11", "total frozen", int'(sad_total), saved);

        // R10: frame start while outputs are flowing
        cur_req = "R10";
        send_rand(2);
        fs_req = 1'b1;
        send_rand(5);
        drain();
        check(sb.size() == 0, "R5", "scoreboard empty", sb.size(), 0);

        finish_up();
    end

endmodule